// File: doc/BRIEF.md
# Programmable pulse burst generator

The block drives a DAC sample bus with a finite train of rectangular pulses. Four programmed values set the train: the pulse width and the pulse period, both counted in DAC clock cycles, the number of pulses, and the amplitude driven during the high part of each pulse. A start strobe arms the train. In each period the output holds the amplitude for the programmed width and is zero for the rest of the period. When the last period ends, the block goes idle and gives a one-cycle completion pulse.

The busy output is high for the whole train and can drive a status LED. A soft reset input stops a train at once. The configuration is captured when the train starts, so software can write the next settings while a train is running. The DAC clock is expected to run at 125 MHz. The logic uses only the one clock, so it works at any rate that meets timing.

Top module: `pulse_burst_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it goes high, `busy` = 0, `done` = 0 and `dac_data` = 0.
- R2: A start is accepted only when all of these hold at a rising edge: `start` = 1, `busy` = 0, `soft_rst` = 0, and `cfg_width`, `cfg_period` and `cfg_count` are all nonzero. `busy` is then 1 from that edge for exactly `cfg_count` × `cfg_period` cycles.
- R3: Number the cycles of a train k = 0, 1, … starting at the accepting edge. In cycle k, `dac_data` equals the latched amplitude when (k mod period) < width, and 0 otherwise. If width ≥ period, the output is high for every cycle of the train.
- R4: Width, period, count and amplitude are captured at the accepting edge. Changes on the `cfg_*` inputs while `busy` = 1 do not alter the running train.
- R5: A `start` pulse while `busy` = 1 is ignored. It neither restarts nor lengthens the train.
- R6: A `start` with a zero width, zero period or zero count is ignored, and the block stays idle.
- R7: `done` is 1 for exactly one cycle: the first cycle after a train ends normally, which is also the first cycle with `busy` = 0.
- R8: When `soft_rst` = 1 at an edge, the next cycle has `busy` = 0 and `dac_data` = 0, and `done` stays 0. `soft_rst` takes priority over `start`.
- R9: While `busy` = 0, `dac_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DAC sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | TW | High time per pulse, in clock cycles |
| cfg_period | input | TW | Pulse repetition period, in clock cycles |
| cfg_count | input | NW | Number of pulses in a train |
| cfg_amp | input | DW | Sample value driven during the high time |
| start | input | 1 | Arm-and-go strobe |
| soft_rst | input | 1 | Abort the train and go idle |
| dac_data | output | DW | Sample bus to the DAC |
| busy | output | 1 | A train is running (LED status) |
| done | output | 1 | One-cycle end-of-train pulse |

## Verification
The assertions assume that `start` and `soft_rst` are synchronous to `clk` and that `rst_n` is held low for at least one edge before use. They also assume that the `cfg_*` inputs are stable only at the accepting edge; after that edge they may change freely. The stimulus respects these assumptions: inputs change only on falling edges, reset is held for several cycles, and the random widths, periods and counts are kept small (period up to 20, count up to 6) so that each train ends quickly. The random stimulus also changes the `cfg_*` inputs mid-train and issues stray starts while the block is busy.

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen #(
  parameter int DW = 14,
  parameter int TW = 32,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cfg_width,
  input  logic [TW-1:0] cfg_period,
  input  logic [NW-1:0] cfg_count,
  input  logic [DW-1:0] cfg_amp,
  input  logic          start,
  input  logic          soft_rst,
  output logic [DW-1:0] dac_data,
  output logic          busy,
  output logic          done
);

  logic [TW-1:0] w_q, p_q, phase;
  logic [NW-1:0] n_q, idx;
  logic [DW-1:0] a_q;

  wire cfg_ok   = (|cfg_width) && (|cfg_period) && (|cfg_count);
  wire go       = start && !busy && !soft_rst && cfg_ok;
  wire per_end  = (phase == p_q - 1'b1);
  wire last_pls = (idx == n_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= '0;
      idx   <= '0;
      w_q   <= '0;
      p_q   <= '0;
      n_q   <= '0;
      a_q   <= '0;
    end else begin
      done <= 1'b0;
      if (soft_rst) begin
        busy  <= 1'b0;
        phase <= '0;
        idx   <= '0;
      end else if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          phase <= '0;
          idx   <= '0;
          w_q   <= cfg_width;
          p_q   <= cfg_period;
          n_q   <= cfg_count;
          a_q   <= cfg_amp;
        end
      end else if (per_end) begin
        phase <= '0;
        if (last_pls) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign dac_data = (busy && phase < w_q) ? a_q : '0;

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy && !done);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !soft_rst && cfg_ok) |=> busy);
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> phase < p_q);
  p_cfg_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(a_q) && $stable(w_q) && $stable(p_q) && $stable(n_q)));
  p_bad_cfg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_ok) |=> !busy);
  p_done_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !done && dac_data == '0));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dac_data == '0);

endmodule

// File: tb/pulse_burst_gen_bench.sv
module pulse_burst_gen_bench;
  localparam int DW = 14, TW = 32, NW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, soft_rst = 1'b0;
  logic [TW-1:0] cfg_width = '0, cfg_period = '0;
  logic [NW-1:0] cfg_count = '0;
  logic [DW-1:0] cfg_amp = '0;
  logic [DW-1:0] dac_data;
  logic busy, done;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  pulse_burst_gen #(.DW(DW), .TW(TW), .NW(NW)) u_pulse_burst_gen (
    .clk, .rst_n, .cfg_width, .cfg_period, .cfg_count, .cfg_amp,
    .start, .soft_rst, .dac_data, .busy, .done);

  function automatic logic [DW-1:0] exp_data(int k, int w, int p, int n, logic [DW-1:0] a);
    if (k >= n * p) return '0;
    return ((k % p) < w) ? a : '0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // abort_at < 0: no soft reset; stray: start pulse mid-train; scramble: change cfg mid-train
  task automatic burst(int w, int p, int n, logic [DW-1:0] a, int abort_at, bit stray, bit scramble);
    int total = n * p;
    cfg_width = w; cfg_period = p; cfg_count = n; cfg_amp = a;
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int k = 0; k <= total + 1; k++) begin
      if (abort_at >= 0 && k == abort_at + 1) begin
        chk("R8 busy", busy, 0); chk("R8 data", dac_data, 0); chk("R8 done", done, 0);
        break;
      end
      chk("R2 busy", busy, k < total);
      chk("R3 data", dac_data, exp_data(k, w, p, n, a));
      chk("R7 done", done, k == total);
      if (k == total + 1) chk("R9 idle data", dac_data, 0);
      if (scramble && k == 0) begin
        cfg_width = $urandom_range(1, 30); cfg_period = $urandom_range(1, 30);
        cfg_count = $urandom_range(1, 9); cfg_amp = $urandom; // R4
      end
      start = stray && (k == 1);     // R5
      soft_rst = (k == abort_at);
      tick();
      start = 1'b0;
      soft_rst = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) tick();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 data", dac_data, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 busy after", busy, 0); chk("R1 done after", done, 0);

    burst(3, 8, 3, 14'h1abc, -1, 0, 0);
    burst(1, 1, 1, 14'h3fff, -1, 0, 0);
    burst(9, 5, 2, 14'h0123, -1, 0, 0);   // R3 width >= period
    burst(5, 5, 2, 14'h0555, -1, 0, 0);
    burst(4, 7, 4, 14'h2222, -1, 1, 1);   // R4 R5
    burst(2, 6, 5, 14'h1111, 8, 0, 0);    // R8 abort
    // R6 zero configs ignored
    for (int z = 0; z < 3; z++) begin
      cfg_width = (z == 0) ? 0 : 4; cfg_period = (z == 1) ? 0 : 4;
      cfg_count = (z == 2) ? 0 : 2; cfg_amp = 14'h0aaa;
      start = 1'b1; tick(); start = 1'b0;
      chk("R6 busy", busy, 0); chk("R6 data", dac_data, 0);
      tick(); chk("R6 done", done, 0);
    end
    // R8 soft reset beats start
    cfg_width = 2; cfg_period = 3; cfg_count = 2; cfg_amp = 14'h0f0f;
    start = 1'b1; soft_rst = 1'b1; tick(); start = 1'b0; soft_rst = 1'b0;
    chk("R8 priority busy", busy, 0); chk("R8 priority data", dac_data, 0);

    for (int i = 0; i < 40; i++) begin
      int w = $urandom_range(1, 24);
      int p = $urandom_range(1, 20);
      int n = $urandom_range(1, 6);
      int ab = ($urandom_range(0, 4) == 0) ? $urandom_range(0, n * p - 1) : -1;
      burst(w, p, n, DW'($urandom), ab, $urandom_range(0, 1), $urandom_range(0, 1));
      repeat ($urandom_range(0, 2)) tick();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule